// File: doc/BRIEF.md
# Two-Phase SPI ADC Conversion Sequencer

This block is a free-running SPI master for a 12-bit sampling ADC that is wired with two active-low select lines: a convert strobe (`rc_n`) and a chip select (`cs_n`). Every sample uses a pair of serial frames. The first frame is 8 SCK periods long with both selects low, and it starts a conversion. The second frame is 12 SCK periods long with only the chip select low. During that frame the result of the conversion comes in on `miso`, most significant bit first. After each frame the block waits for a gap whose length is set by `delay_cfg`. It then moves on without any software action, so the sample rate depends only on the system clock.

SCK is the system clock divided by four. It idles low, and `miso` is sampled on each rising edge (mode 0). While the block is idle, both selects stay high. This keeps the converter's data pin in high impedance, so the line can be shared, and it ensures that no conversion starts. When enable is removed, the current frame pair and its trailing gap still run to the end. The gap length is captured once at the start of each pair.

The time from one sample to the next is 80 + 2·(D+1) system clocks, where D is the captured `delay_cfg`.

Top module: `adc_pair_seq`

## Requirements
- R1: While `rst_n` is low, at each clock edge `sck` becomes 0, `cs_n` and `rc_n` become 1, `result` becomes 0 and `result_valid` becomes 0.
- R2: While idle with `enable` low, `cs_n` and `rc_n` stay 1, `sck` stays 0, and `miso` has no effect on `result` or `result_valid`.
- R3: The clock edge that samples `enable` high in idle starts a trigger frame. During this frame `cs_n` and `rc_n` are both 0 for exactly 32 clock cycles, and `sck` gives 8 rising edges.
- R4: A readout frame holds `cs_n` at 0 and `rc_n` at 1 for exactly 48 clock cycles, and `sck` gives 12 rising edges. `rc_n` is never 0 while `cs_n` is 1.
- R5: Each frame is followed by a gap of exactly D+1 clock cycles, in which both selects are 1 and `sck` is 0. D is the captured delay value.
- R6: Within a frame, `sck` has a period of 4 clocks: it is low for 2 cycles and then high for 2 cycles, starting low in the first cycle with the selects low. `sck` is 0 whenever `cs_n` is 1.
- R7: `miso` is sampled at each rising `sck` edge of the readout frame only. The first sampled bit becomes `result[11]` and the last becomes `result[0]`. Bits seen during the trigger frame or the gaps are ignored.
- R8: `result_valid` is 1 for exactly one cycle per pair: the first cycle after the readout frame, in which `cs_n` is 1 again. `result` changes only at that point and holds its value until the next pulse.
- R9: With `enable` held high, the next trigger frame begins in the cycle right after the second gap ends, with no idle cycle between them.
- R10: If `enable` falls at any point in a pair, the pair and its second gap still complete. The block then returns to idle (selects 1, `sck` 0).
- R11: D is `delay_cfg` as sampled at the clock edge that starts a trigger frame. Changes to `delay_cfg` later in the pair do not alter either gap of that pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; when low, the block stops after the current pair |
| delay_cfg | input | DLY_W | Gap length minus one, in system clocks |
| miso | input | 1 | Serial data from the converter |
| sck | output | 1 | Serial clock, system clock / 4, idles low |
| rc_n | output | 1 | Active-low convert strobe |
| cs_n | output | 1 | Active-low chip select |
| result | output | 12 | Last received conversion word |
| result_valid | output | 1 | One-cycle strobe when `result` updates |

## Verification
A wrong internal state shows up at the pins within one frame. A bit counter that is off by one changes the width of a select window by four clocks, and a faulty phase counter breaks the SCK pattern within two cycles. A gap counter or delay latch fault moves the next select edge by a full cycle. A faulty shift path or capture point changes the word reported at the `result_valid` pulse, and this is visible at the end of the first readout frame that carries a non-symmetric pattern.

// File: rtl/adcseq_pkg.sv
// Shared constants and state encoding for the two-phase ADC sequencer.
// Assumes a fixed SCK divide ratio that is even and at least 2.
package adcseq_pkg;
    localparam int TRIG_BITS = 8;                     // SCK periods in the convert frame
    localparam int READ_BITS = 12;                    // SCK periods in the readout frame
    localparam int SCK_DIV   = 4;                     // system clocks per SCK period
    localparam int PH_W      = $clog2(SCK_DIV);
    localparam int BIT_W     = $clog2(READ_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TRIG  = 3'd1,
        ST_GAP_A = 3'd2,
        ST_READ  = 3'd3,
        ST_GAP_B = 3'd4
    } seq_state_t;
endpackage

// File: rtl/sck_divider.sv
// Serial clock generator. While run is high it produces a divided clock
// that is low for the first half of each period and high for the second.
// It also gives one-cycle strobes at the rising and falling edges.
// Assumes run stays high for whole SCK periods. When run is low, the phase
// returns to zero and the clock goes to its low idle level.
module sck_divider #(
    parameter int DIV  = 4,
    parameter int PH_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = DIV / 2;

    logic [PH_W-1:0] phase;

    // Strobes mark the system-clock edges at which SCK will toggle.
    assign rise_stb = run && (phase == PH_W'(HALF - 1));
    assign fall_stb = run && (phase == PH_W'(DIV - 1));

    // Phase counter: advances once per system clock while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            phase <= '0;
        else if (phase == PH_W'(DIV - 1))
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // SCK register: rises at mid-period and falls at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            sck <= 1'b0;
        else if (rise_stb)
            sck <= 1'b1;
        else if (fall_stb)
            sck <= 1'b0;
    end

    // SCK must never be high outside an active frame.
    p_sck_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck);
endmodule

// File: rtl/rx_shift.sv
// Serial-to-parallel receiver. On each shift strobe it moves the word up by
// one and puts the input bit at the bottom, so the first bit taken ends up
// as the MSB once W strobes have been seen.
// Assumes the caller gives exactly W strobes per word.
module rx_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    // Shift register: MSB-first assembly of the incoming word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (shift_en)
            word <= {word[W-2:0], din};
    end

    // The register holds its value between strobes.
    p_shift_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/gap_timer.sv
// Inter-frame gap timer. While active is high it counts system clocks and
// raises expired in the cycle where the count reaches limit, so one gap
// lasts limit+1 cycles.
// Assumes limit stays stable while active is high.
module gap_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = active && (cnt == limit);

    // Gap counter: clears outside a gap and when the gap ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || expired)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // The count never passes the limit during a gap.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= limit));
endmodule

// File: rtl/adc_pair_seq.sv
// Two-phase SPI conversion sequencer (top). It repeats the sequence
// convert frame, gap, readout frame, gap while enable is high. It stops
// only at a pair boundary and captures the gap length once per pair.
// Assumes the converter drives miso so that it is stable at each rising SCK
// edge of the readout frame.
module adc_pair_seq
    import adcseq_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [DLY_W-1:0]     delay_cfg,
    input  logic                 miso,
    output logic                 sck,
    output logic                 rc_n,
    output logic                 cs_n,
    output logic [READ_BITS-1:0] result,
    output logic                 result_valid
);
    seq_state_t           st, nxt;
    logic                 run, rise_stb, fall_stb;
    logic                 gap_active, gap_done, frame_last;
    logic [BIT_W-1:0]     bit_cnt;
    logic [BIT_W-1:0]     frame_top;
    logic [DLY_W-1:0]     dly_lat;
    logic [READ_BITS-1:0] rx_word;

    assign run        = (st == ST_TRIG) || (st == ST_READ);
    assign gap_active = (st == ST_GAP_A) || (st == ST_GAP_B);
    assign frame_top  = (st == ST_READ) ? BIT_W'(READ_BITS - 1) : BIT_W'(TRIG_BITS - 1);
    assign frame_last = fall_stb && (bit_cnt == frame_top);

    sck_divider #(.DIV(SCK_DIV), .PH_W(PH_W)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sck      (sck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    rx_shift #(.W(READ_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rise_stb && (st == ST_READ)),
        .din      (miso),
        .word     (rx_word)
    );

    gap_timer #(.W(DLY_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (gap_active),
        .limit   (dly_lat),
        .expired (gap_done)
    );

    // Next-state logic: walks through the fixed frame pair.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (enable)     nxt = ST_TRIG;
            ST_TRIG:  if (frame_last) nxt = ST_GAP_A;
            ST_GAP_A: if (gap_done)   nxt = ST_READ;
            ST_READ:  if (frame_last) nxt = ST_GAP_B;
            ST_GAP_B: if (gap_done)   nxt = enable ? ST_TRIG : ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    // State register and select outputs, registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cs_n <= 1'b1;
            rc_n <= 1'b1;
        end else begin
            st   <= nxt;
            cs_n <= !((nxt == ST_TRIG) || (nxt == ST_READ));
            rc_n <= !(nxt == ST_TRIG);
        end
    end

    // Delay capture: sampled only on entry to a trigger frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly_lat <= '0;
        else if ((nxt == ST_TRIG) && (st != ST_TRIG))
            dly_lat <= delay_cfg;
    end

    // Bit counter: counts completed SCK periods in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            bit_cnt <= '0;
        else if (fall_stb)
            bit_cnt <= frame_last ? '0 : bit_cnt + 1'b1;
    end

    // Result register and its one-cycle strobe at the end of readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= (st == ST_READ) && frame_last;
            if ((st == ST_READ) && frame_last)
                result <= rx_word;
        end
    end

    p_rc_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_n |-> !cs_n);
    p_sck_off_when_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    p_rise_only_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> !cs_n);
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    p_valid_after_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (cs_n && rc_n));
    p_idle_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (cs_n && rc_n && !sck));
    p_read_rc_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ) |-> (rc_n && !cs_n));
    p_dly_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ) |-> $stable(dly_lat));
endmodule

// File: tb/adc_pair_seq_tb_top.sv
`timescale 1ns/1ps
module adc_pair_seq_tb_top;
    localparam int DLY_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             enable;
    logic [DLY_W-1:0] delay_cfg;
    logic             miso;
    logic             sck, rc_n, cs_n, result_valid;
    logic [11:0]      result;

    int total = 0;
    int bad   = 0;
    logic [11:0] prev_res;

    always #2 clk = ~clk;

    adc_pair_seq #(.DLY_W(DLY_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .delay_cfg    (delay_cfg),
        .miso         (miso),
        .sck          (sck),
        .rc_n         (rc_n),
        .cs_n         (cs_n),
        .result       (result),
        .result_valid (result_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected SCK level at offset k inside a frame (R6).
    function automatic logic exp_sck(input int k);
        return (k % 4) >= 2;
    endfunction

    // Runs one frame pair starting at the negedge of its first cycle and
    // checks every cycle against the timing computed from d.
    task automatic run_pair(input int d, input logic [11:0] word,
                            input logic [DLY_W-1:0] new_cfg, input bit drop_en,
                            input bit chained);
        int rd0 = 32 + d + 1;
        int gb0 = rd0 + 48;
        int len = gb0 + d + 1;
        int e_trig = 0, e_read = 0, e_gap = 0, e_sck = 0, e_res = 0, e_val = 0;
        int rises_t = 0, rises_r = 0;
        logic last_sck = 1'b0;
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            if (t == 0 && chained)
                chk(cs_n == 1'b0 && rc_n == 1'b0, "R9 back-to-back start", cs_n, 0);
            if (t < 32) begin
                if (cs_n !== 1'b0 || rc_n !== 1'b0) e_trig++;
                if (sck !== exp_sck(t)) e_sck++;
                if (sck && !last_sck) rises_t++;
            end else if (t < rd0) begin
                if (cs_n !== 1'b1 || rc_n !== 1'b1 || sck !== 1'b0) e_gap++;
            end else if (t < gb0) begin
                if (cs_n !== 1'b0 || rc_n !== 1'b1) e_read++;
                if (sck !== exp_sck(t - rd0)) e_sck++;
                if (sck && !last_sck) rises_r++;
            end else begin
                if (cs_n !== 1'b1 || rc_n !== 1'b1 || sck !== 1'b0) e_gap++;
            end
            last_sck = sck;
            if (result_valid !== (t == gb0)) e_val++;
            if (result !== ((t < gb0) ? prev_res : word)) e_res++;
            // drive miso for the edge closing this cycle; junk outside readout
            if (t >= rd0 && t < gb0)
                miso = word[11 - (t - rd0) / 4];
            else
                miso = 1'($urandom);
            if (t == 3) delay_cfg = new_cfg;   // R11: mid-pair change
            if (t == 10 && drop_en) enable = 1'b0;
        end
        chk(e_trig == 0 && rises_t == 8, "R3 trigger frame", rises_t, 8);
        chk(e_read == 0 && rises_r == 12, "R4 readout frame", rises_r, 12);
        chk(e_gap == 0, "R5/R11 gap length", e_gap, 0);
        chk(e_sck == 0, "R6 sck waveform", e_sck, 0);
        chk(e_res == 0, "R7 result word", result, word);
        chk(e_val == 0, "R8 valid pulse", e_val, 0);
        prev_res = word;
    endtask

    task automatic idle_check(input int n, input string req);
        int e = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cs_n !== 1'b1 || rc_n !== 1'b1 || sck !== 1'b0 ||
                result_valid !== 1'b0 || result !== prev_res) e++;
            miso = 1'($urandom);
        end
        chk(e == 0, req, e, 0);
    endtask

    initial begin
        int d;
        logic [DLY_W-1:0] nc;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; enable = 1'b0; delay_cfg = '0; miso = 1'b0; prev_res = '0;
        repeat (4) @(negedge clk);
        chk(sck == 0 && cs_n == 1 && rc_n == 1 && result == 0 && result_valid == 0,
            "R1 reset state", {sck, cs_n, rc_n, result_valid}, 4'b0110);
        rst_n = 1'b1;
        idle_check(20, "R2 idle while disabled");

        // directed corners: zero delay, all-ones/zeros, MSB-only, LSB-only
        delay_cfg = '0; enable = 1'b1;
        run_pair(0, 12'hFFF, 0, 0, 0);
        run_pair(0, 12'h000, 5, 0, 1);
        run_pair(5, 12'h800, 1, 0, 1);
        run_pair(1, 12'h001, 319, 0, 1);
        run_pair(319, 12'hA5A, 3, 1, 1);
        idle_check(30, "R10 stop after pair");

        // random pairs
        d = int'(delay_cfg);
        enable = 1'b1;
        for (int i = 0; i < 7; i++) begin
            nc = DLY_W'($urandom_range(0, 40));
            run_pair(d, 12'($urandom), nc, i == 6, i != 0);
            d = int'(nc);
        end
        idle_check(25, "R10 stop after random run");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule